// File: doc/BRIEF.md
# Receive Byte Buffer with Interrupt Status

This block sits between the receive framer of a contactless reader front end and a host microcontroller. The framer hands it a start-of-frame pulse, one strobe per decoded byte, an end-of-frame pulse and separate framing and CRC error pulses. The block stores the bytes in a 12-entry first-in first-out buffer. It gathers the events into an interrupt status register and drives one interrupt line toward the host.

The host sees a small read port. Reading address 0x0C returns the interrupt status and clears it. Reading 0x1C returns the buffer status, which holds the fill level and a sticky overflow bit. Reading 0x1F returns the oldest byte and removes it.

A frame of eight bytes or fewer interrupts the host only once, at its end. A longer frame also interrupts early, when the ninth byte is stored. The host can then start draining before the frame completes. Once the frame ends, the host uses the fill level to fetch the bytes that remain.

Top module: `rx_fifo_irq`

## Requirements
- R1: Bytes come out of address 0x1F in arrival order, and each such read removes one byte. Buffer status bits 3:0 give the number of stored bytes, from 0 to 12. A read of 0x1F on an empty buffer returns 0x00 and changes nothing.
- R2: A start-of-frame pulse sets bit 6 of the interrupt status register on the next clock edge. It does not assert the interrupt line.
- R3: A byte that arrives while 12 bytes are stored is dropped. On the same edge it sets buffer status bit 7, which stays set until the next start-of-frame pulse, unless a byte is dropped in that same cycle.
- R4: When a byte is stored and the level goes from 8 to 9, with no removal in the same cycle, bit 5 of the interrupt status is set and the interrupt line rises. A level that stays at 9 or more does not set bit 5 again.
- R5: While a frame of 8 bytes or fewer is received, the interrupt line stays low until the end of the frame, as long as no error occurs.
- R6: An end-of-frame pulse sets bit 7 of the interrupt status and asserts the interrupt line. This holds even when a 75% interrupt was already raised in the same frame.
- R7: A framing error pulse sets status bit 0 and a CRC error pulse sets status bit 1. Either one asserts the interrupt line.
- R8: A read of address 0x0C returns the status in the same cycle and clears every flag on the following edge, which drops the interrupt line. An event in the same cycle as the read sets its flag anyway.
- R9: After reset the interrupt status is 0x00, the buffer status is 0x00 and the interrupt line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sof_i | input | 1 | Start-of-frame detected, one-cycle pulse |
| byte_valid_i | input | 1 | Decoded byte strobe |
| byte_data_i | input | 8 | Decoded byte |
| eof_i | input | 1 | End of reception, one-cycle pulse |
| frame_err_i | input | 1 | Framing error pulse |
| crc_err_i | input | 1 | CRC error pulse |
| rd_en_i | input | 1 | Host read strobe |
| rd_addr_i | input | 5 | Host read address |
| rd_data_o | output | 8 | Read data for the addressed register |
| irq_o | output | 1 | Interrupt request to the host |

## Verification
Directed frames come first. A short frame of eight bytes checks that the interrupt stays silent until the end. A long frame of thirteen bytes separates the single early 75% interrupt from the end interrupt and from the overflow drop. Error pulses and reads that collide with events show whether a set wins over a clear. A long random run then mixes pushes, pops, status reads and frame events, so that simultaneous push and pop near the 8/9 and full levels are tried. A reference queue and a flag model in the bench score every read and the interrupt line.

// File: rtl/rx_fifo_pkg.sv
package rx_fifo_pkg;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] ADDR_IRQ   = 5'h0C;
  localparam logic [ADDR_W-1:0] ADDR_FSTAT = 5'h1C;
  localparam logic [ADDR_W-1:0] ADDR_FDATA = 5'h1F;

  localparam int FLAG_W     = 8;
  localparam int BIT_FRAME  = 0;
  localparam int BIT_CRC    = 1;
  localparam int BIT_HIGH   = 5;
  localparam int BIT_SOF    = 6;
  localparam int BIT_DONE   = 7;

  // flags that wake the host; start-of-frame alone does not
  localparam logic [FLAG_W-1:0] WAKE_MASK =
    FLAG_W'((1 << BIT_DONE) | (1 << BIT_HIGH) | (1 << BIT_CRC) | (1 << BIT_FRAME));
endpackage

// File: rtl/rx_byte_fifo.sv
module rx_byte_fifo #(
  parameter int DEPTH     = 12,
  parameter int DW        = 8,
  parameter int HIGH_MARK = 9,
  localparam int LVL_W    = $clog2(DEPTH + 1),
  localparam int PTR_W    = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             pop_i,
  input  logic             clr_ovf_i,
  output logic [DW-1:0]    rdata_o,
  output logic [LVL_W-1:0] level_o,
  output logic             ovf_o,
  output logic             high_evt_o
);
  localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);
  localparam logic [LVL_W-1:0] LVL_PRE  = LVL_W'(HIGH_MARK - 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [DW-1:0]    mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [LVL_W-1:0] level_q;
  logic             ovf_q;
  logic             push_ok, pop_ok, drop;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  assign push_ok = push_i && (level_q != LVL_FULL);
  assign drop    = push_i && (level_q == LVL_FULL);
  assign pop_ok  = pop_i && (level_q != '0);

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
      ovf_q    <= 1'b0;
    end else begin
      if (push_ok) wr_ptr_q <= ptr_next(wr_ptr_q);
      if (pop_ok)  rd_ptr_q <= ptr_next(rd_ptr_q);
      case ({push_ok, pop_ok})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
      if (drop)           ovf_q <= 1'b1;
      else if (clr_ovf_i) ovf_q <= 1'b0;
    end
  end

  assign rdata_o    = (level_q != '0) ? mem_q[rd_ptr_q] : '0;
  assign level_o    = level_q;
  assign ovf_o      = ovf_q;
  assign high_evt_o = push_ok && !pop_ok && (level_q == LVL_PRE);
endmodule

// File: rtl/rx_irq_ctrl.sv
module rx_irq_ctrl
  import rx_fifo_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FLAG_W-1:0] set_i,
  input  logic              clr_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic              irq_o
);
  logic [FLAG_W-1:0] flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (clr_i ? '0 : flags_q) | set_i;
  end

  assign flags_o = flags_q;
  assign irq_o   = |(flags_q & WAKE_MASK);
endmodule

// File: rtl/rx_fifo_irq.sv
module rx_fifo_irq
  import rx_fifo_pkg::*;
#(
  parameter int DEPTH     = 12,
  parameter int HIGH_MARK = DEPTH * 3 / 4,
  localparam int LVL_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sof_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_data_i,
  input  logic              eof_i,
  input  logic              frame_err_i,
  input  logic              crc_err_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              irq_o
);
  logic [7:0]        head_byte;
  logic [LVL_W-1:0]  level;
  logic              ovf, high_evt;
  logic              rd_irq, rd_fstat, rd_fdata;
  logic [FLAG_W-1:0] flag_set, irq_flags;
  logic [7:0]        fstat;

  assign rd_irq   = rd_en_i && (rd_addr_i == ADDR_IRQ);
  assign rd_fstat = rd_en_i && (rd_addr_i == ADDR_FSTAT);
  assign rd_fdata = rd_en_i && (rd_addr_i == ADDR_FDATA);

  rx_byte_fifo #(
    .DEPTH    (DEPTH),
    .DW       (8),
    .HIGH_MARK(HIGH_MARK)
  ) i_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (byte_valid_i),
    .wdata_i   (byte_data_i),
    .pop_i     (rd_fdata),
    .clr_ovf_i (sof_i),
    .rdata_o   (head_byte),
    .level_o   (level),
    .ovf_o     (ovf),
    .high_evt_o(high_evt)
  );

  always_comb begin
    flag_set            = '0;
    flag_set[BIT_SOF]   = sof_i;
    flag_set[BIT_HIGH]  = high_evt;
    flag_set[BIT_DONE]  = eof_i;
    flag_set[BIT_FRAME] = frame_err_i;
    flag_set[BIT_CRC]   = crc_err_i;
  end

  rx_irq_ctrl i_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (flag_set),
    .clr_i  (rd_irq),
    .flags_o(irq_flags),
    .irq_o  (irq_o)
  );

  assign fstat = {ovf, (7 - LVL_W)'(0), level};

  always_comb begin
    rd_data_o = '0;
    if (rd_irq)   rd_data_o = irq_flags;
    if (rd_fstat) rd_data_o = fstat;
    if (rd_fdata) rd_data_o = head_byte;
  end
endmodule

// File: rtl/rx_fifo_irq_chk.sv
module rx_fifo_irq_chk
  import rx_fifo_pkg::*;
#(
  parameter int DEPTH     = 12,
  parameter int HIGH_MARK = 9,
  localparam int LVL_W    = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sof_i,
  input logic              byte_valid_i,
  input logic              eof_i,
  input logic              frame_err_i,
  input logic              crc_err_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic              irq_o,
  input logic [FLAG_W-1:0] flags_i,
  input logic [LVL_W-1:0]  level_i,
  input logic              ovf_i
);
  logic pop_req, irq_read, any_wake;
  assign pop_req  = rd_en_i && (rd_addr_i == ADDR_FDATA);
  assign irq_read = rd_en_i && (rd_addr_i == ADDR_IRQ);
  assign any_wake = eof_i || frame_err_i || crc_err_i ||
                    (byte_valid_i && level_i == LVL_W'(HIGH_MARK - 1));

  assert_level_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_i <= LVL_W'(DEPTH));

  assert_sof_flag_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |=> flags_i[BIT_SOF]);

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && level_i == LVL_W'(DEPTH)) |=> ovf_i);

  assert_high_mark_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && !pop_req && level_i == LVL_W'(HIGH_MARK - 1)) |=> (flags_i[BIT_HIGH] && irq_o));

  assert_irq_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(any_wake));

  assert_done_irq_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_i |=> (irq_o && flags_i[BIT_DONE]));

  assert_frame_err_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_i |=> (flags_i[BIT_FRAME] && irq_o));

  assert_crc_err_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_err_i |=> (flags_i[BIT_CRC] && irq_o));

  assert_read_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_read && !any_wake && !sof_i) |=> (flags_i == '0 && !irq_o));
endmodule

bind rx_fifo_irq rx_fifo_irq_chk #(
  .DEPTH    (DEPTH),
  .HIGH_MARK(HIGH_MARK)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sof_i       (sof_i),
  .byte_valid_i(byte_valid_i),
  .eof_i       (eof_i),
  .frame_err_i (frame_err_i),
  .crc_err_i   (crc_err_i),
  .rd_en_i     (rd_en_i),
  .rd_addr_i   (rd_addr_i),
  .irq_o       (irq_o),
  .flags_i     (irq_flags),
  .level_i     (level),
  .ovf_i       (ovf)
);

// File: tb/test_rx_fifo_irq.sv
module test_rx_fifo_irq;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] A_IRQ = 5'h0C, A_FST = 5'h1C, A_FDAT = 5'h1F;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sof = 0, bv = 0, eof = 0, fe = 0, ce = 0, rd = 0;
  logic [7:0] bdata = '0;
  logic [4:0] addr = '0;
  logic [7:0] rd_data;
  logic irq;

  int n_chk = 0, n_err = 0;
  logic [7:0] q[$];
  logic [7:0] m_flags = '0;
  bit m_ovf = 0;
  logic [7:0] last_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_fifo_irq i_rx_fifo_irq (
    .clk_i(clk), .rst_ni(rst_n), .sof_i(sof), .byte_valid_i(bv), .byte_data_i(bdata),
    .eof_i(eof), .frame_err_i(fe), .crc_err_i(ce), .rd_en_i(rd), .rd_addr_i(addr),
    .rd_data_o(rd_data), .irq_o(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [4:0] a);
    case (a)
      A_IRQ:  return m_flags;
      A_FST:  return {m_ovf, 3'b000, 4'(q.size())};
      A_FDAT: return (q.size() != 0) ? q[0] : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  function automatic bit exp_irq();
    return |(m_flags & 8'hA3);
  endfunction

  task automatic cyc(input bit s, input bit v, input logic [7:0] d, input bit e,
                     input bit f, input bit c, input bit r, input logic [4:0] a);
    int cnt;
    bit push_ok, pop_ok, drop, high;
    @(negedge clk);
    sof = s; bv = v; bdata = d; eof = e; fe = f; ce = c; rd = r; addr = a;
    #1;
    if (r) begin
      last_rd = rd_data;
      chk((a == A_IRQ) ? "R8 status read" : (a == A_FST) ? "R3 fifo status" : "R1 fifo data",
          rd_data, exp_read(a));
    end
    cnt     = q.size();
    push_ok = v && cnt < 12;
    drop    = v && cnt == 12;
    pop_ok  = r && a == A_FDAT && cnt > 0;
    high    = push_ok && !pop_ok && cnt == 8;
    @(posedge clk);
    if (pop_ok) void'(q.pop_front());
    if (push_ok) q.push_back(d);
    m_ovf = drop ? 1'b1 : (s ? 1'b0 : m_ovf);
    if (r && a == A_IRQ) m_flags = '0;
    m_flags |= {e, s, high, 3'b000, c, f};
    #1;
    chk("R5/R6 irq line", irq, exp_irq());
  endtask

  task automatic idle();            cyc(0,0,0,0,0,0,0,0);      endtask
  task automatic push(input logic [7:0] d); cyc(0,1,d,0,0,0,0,0); endtask
  task automatic rdreg(input logic [4:0] a); cyc(0,0,0,0,0,0,1,a); endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    #1;
    chk("R9 irq after reset", irq, 0);
    rst_n = 1'b1;
    rdreg(A_FST); chk("R9 fifo status reset", last_rd, 8'h00);
    rdreg(A_IRQ); chk("R9 irq status reset", last_rd, 8'h00);

    // R2: start of frame alone does not wake
    cyc(1,0,0,0,0,0,0,0);
    chk("R2 no irq on sof", irq, 0);
    rdreg(A_IRQ); chk("R2 sof flag", last_rd, 8'h40);

    // R5: short frame of 8 bytes
    for (int i = 0; i < 8; i++) begin
      push(8'h10 + 8'(i));
      chk("R5 silent short frame", irq, 0);
    end
    cyc(0,0,0,1,0,0,0,0);
    chk("R6 end irq short", irq, 1);
    rdreg(A_IRQ); chk("R6 done flag", last_rd, 8'h80);
    chk("R8 irq dropped after read", irq, 0);
    for (int i = 0; i < 8; i++) begin
      rdreg(A_FDAT); chk("R1 order short", last_rd, 8'h10 + 8'(i));
    end
    rdreg(A_FDAT); chk("R1 empty read", last_rd, 8'h00);
    rdreg(A_FST);  chk("R1 empty level", last_rd, 8'h00);

    // R4, R3, R6: long frame of 13 bytes
    cyc(1,0,0,0,0,0,0,0);
    for (int i = 0; i < 9; i++) push(8'hA0 + 8'(i));
    chk("R4 early irq at ninth", irq, 1);
    rdreg(A_IRQ); chk("R4 high flag", last_rd, 8'h60);
    for (int i = 9; i < 12; i++) begin
      push(8'hA0 + 8'(i));
      chk("R4 no repeat above mark", irq, 0);
    end
    push(8'hEE);
    rdreg(A_FST); chk("R3 overflow and full", last_rd, 8'h8C);
    cyc(0,0,0,1,0,0,0,0);
    chk("R6 end irq after early", irq, 1);
    rdreg(A_IRQ); chk("R6 done after high", last_rd, 8'h80);
    for (int i = 0; i < 12; i++) begin
      rdreg(A_FDAT); chk("R1 order long", last_rd, 8'hA0 + 8'(i));
    end
    rdreg(A_FST); chk("R3 overflow sticky", last_rd, 8'h80);
    cyc(1,0,0,0,0,0,0,0);
    rdreg(A_FST); chk("R3 cleared by sof", last_rd, 8'h00);

    // R7 errors
    rdreg(A_IRQ);
    cyc(0,0,0,0,1,0,0,0); chk("R7 frame irq", irq, 1);
    rdreg(A_IRQ); chk("R7 frame flag", last_rd, 8'h01);
    cyc(0,0,0,0,0,1,0,0); chk("R7 crc irq", irq, 1);
    rdreg(A_IRQ); chk("R7 crc flag", last_rd, 8'h02);

    // R8: set wins over clear in the same cycle
    cyc(0,0,0,1,0,0,1,A_IRQ); chk("R8 read value", last_rd, 8'h00);
    chk("R8 set beats clear", irq, 1);
    rdreg(A_IRQ); chk("R8 flag kept", last_rd, 8'h80);

    // random mix, scored by the reference model in cyc
    for (int k = 0; k < 4000; k++) begin
      int rr, p;
      logic [4:0] a;
      bit r;
      rr = $urandom_range(99);
      r = 1; a = A_FDAT;
      if (rr < 40) r = 0;
      else if (rr < 80) a = A_FDAT;
      else if (rr < 92) a = A_IRQ;
      else if (rr < 98) a = A_FST;
      else a = 5'h03;
      p = $urandom_range(99);
      cyc(p < 3, $urandom_range(99) < 55, 8'($urandom), p >= 3 && p < 6,
          p == 6, p == 7, r, a);
    end
    idle();

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule